// File: doc/BRIEF.md
# Configurable Distributed LUT RAM Tile

This block is a small storage tile made of two 16-entry, 1-bit arrays, here called the F array and the G array. A mode input, held constant outside reset, chooses how the two arrays are presented. They can act as two separate 16x1 single-port memories, as one 32x1 single-port memory, or as one 16x1 memory with a single write port and two read ports.

Writes are synchronous. An array cell is updated only on a rising clock edge while the write enable is high, so the enable gates the clock edge and is not a strobe. Reads are purely combinational in every mode. Each output follows its read address, and in the wide mode also the extra address bit, with no clock involved. The same two data inputs and two address buses are reused differently in each mode.

The three modes act as the block's states. `cfg_mode` selects one of them while reset is asserted, and the mode may change only under reset. The only transition is reset, which clears every cell and enters the selected mode.

Top module: `lutram_tile`

## Requirements
- R1: While `rst_n` is low, and right after it rises, every cell of both arrays reads 0 in every mode.
- R2: Reads are combinational. `dout_f` and `dout_g` reflect a changed address or address bit within the same cycle, with no clock edge between the change and the read.
- R3: While `we` is low, a clock edge changes no stored cell. With the addresses held, both outputs stay unchanged.
- R4: With `cfg_mode`=0 (split 16x2), `din0` is written at `addr_f` into F and `din1` at `addr_g` into G in the same edge. `dout_f` = F[`addr_f`] and `dout_g` = G[`addr_g`]. The two addresses may be equal or different.
- R5: With `cfg_mode`=1 (wide 32x1), `din1` is address bit 4 and `addr_f` gives bits 3..0. Entries 0-15 live in F and entries 16-31 in G. `din0` is the only write data. Both outputs return entry {`din1`,`addr_f`}, and `addr_g` has no effect.
- R6: In wide mode a write changes only the half selected by `din1`. The other half keeps its contents.
- R7: With `cfg_mode`=2 (dual-port), the block is one 16x1 memory. `din0` is written at `addr_f`, `dout_f` reads at `addr_f` and `dout_g` reads at `addr_g`. `din1` is ignored, and both read ports always see the same contents.
- R8: In dual-port mode, a read of the address being written in that cycle returns the old value before the edge and the new value after it. There is no bypass path.
- R9: `cfg_mode`=3 behaves as the split mode. The mode is sampled only while stable outside reset, and a mode change requires reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset, clears all cells |
| cfg_mode | input | 2 | 0 split 16x2, 1 wide 32x1, 2 dual-port, 3 as split |
| addr_f | input | 4 | F-side address; write address in wide and dual-port modes |
| addr_g | input | 4 | G-side address; second read address in dual-port mode |
| din0 | input | 1 | Write data for F (split) or for the whole memory (wide, dual-port) |
| din1 | input | 1 | Write data for G (split) or address bit 4 (wide) |
| we | input | 1 | Write enable, acts as clock enable |
| dout_f | output | 1 | F-side read data |
| dout_g | output | 1 | G-side read data |

## Verification
Each mode is first filled through its own write path with an address-dependent bit pattern. In split mode G is written at a mirrored address, so that writes to the wrong array or at the wrong address show up. The bench then sweeps every pair of F and G read addresses in split and dual-port modes, and all 32 wide entries while `addr_g` is scrambled. These sweeps separate crossed ports, a wrong half selection and a second read port that is not decoded on its own address. Cycles with `we` low and changing data show any leak through the enable. Dual-port writes with both addresses equal are checked just before and just after the edge to show whether the read path bypasses the array.

// File: rtl/lutram_pkg.sv
package lutram_pkg;

    typedef enum logic [1:0] {
        LM_SPLIT = 2'd0,
        LM_WIDE  = 2'd1,
        LM_DUAL  = 2'd2,
        LM_RSVD  = 2'd3
    } lut_mode_e;

endpackage

// File: rtl/lutram_array.sv
module lutram_array #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic          wr_bit,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_bit
);
    localparam int DEPTH = 1 << AW;

    logic [DEPTH-1:0] cells;

    // storage: edge-triggered write, enable acts as clock enable
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cells <= '0;
        end else if (wr_en) begin
            cells[wr_addr] <= wr_bit;
        end
    end

    // read: combinational, no register on the path
    always_comb begin
        rd_bit = cells[rd_addr];
    end

    // R3: cells only change under an enabled edge
    a_r3_cells_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cells));

endmodule

// File: rtl/lutram_route.sv
module lutram_route
    import lutram_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  lut_mode_e     mode,
    input  logic [AW-1:0] addr_f,
    input  logic [AW-1:0] addr_g,
    input  logic          din0,
    input  logic          din1,
    input  logic          we,
    input  logic          f_rd,
    input  logic          g_rd,
    output logic          f_we,
    output logic [AW-1:0] f_waddr,
    output logic          f_wbit,
    output logic [AW-1:0] f_raddr,
    output logic          g_we,
    output logic [AW-1:0] g_waddr,
    output logic          g_wbit,
    output logic [AW-1:0] g_raddr,
    output logic          dout_f,
    output logic          dout_g
);
    // write-side and address steering per mode
    always_comb begin
        f_we    = we;
        g_we    = we;
        f_waddr = addr_f;
        g_waddr = addr_g;
        f_wbit  = din0;
        g_wbit  = din1;
        f_raddr = addr_f;
        g_raddr = addr_g;
        unique case (mode)
            LM_WIDE: begin
                f_we    = we & ~din1;
                g_we    = we & din1;
                g_waddr = addr_f;
                g_wbit  = din0;
                g_raddr = addr_f;
            end
            LM_DUAL: begin
                g_waddr = addr_f;
                g_wbit  = din0;
            end
            LM_SPLIT, LM_RSVD: begin
            end
            default: begin
            end
        endcase
    end

    // read-side output selection per mode
    always_comb begin
        dout_f = f_rd;
        dout_g = g_rd;
        unique case (mode)
            LM_WIDE: begin
                dout_f = din1 ? g_rd : f_rd;
                dout_g = din1 ? g_rd : f_rd;
            end
            LM_SPLIT, LM_DUAL, LM_RSVD: begin
            end
            default: begin
            end
        endcase
    end

    // R6: a wide-mode write touches exactly the half chosen by din1
    a_r6_one_half: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LM_WIDE) |-> $onehot0({f_we, g_we}) && (!f_we || !din1) && (!g_we || din1));

endmodule

// File: rtl/lutram_tile.sv
module lutram_tile
    import lutram_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    cfg_mode,
    input  logic [AW-1:0] addr_f,
    input  logic [AW-1:0] addr_g,
    input  logic          din0,
    input  logic          din1,
    input  logic          we,
    output logic          dout_f,
    output logic          dout_g
);
    localparam int NARR = 2;

    lut_mode_e mode;
    assign mode = lut_mode_e'(cfg_mode);

    logic [NARR-1:0]         arr_we;
    logic [NARR-1:0][AW-1:0] arr_waddr;
    logic [NARR-1:0]         arr_wbit;
    logic [NARR-1:0][AW-1:0] arr_raddr;
    logic [NARR-1:0]         arr_rbit;

    lutram_route #(.AW(AW)) u_route (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .addr_f  (addr_f),
        .addr_g  (addr_g),
        .din0    (din0),
        .din1    (din1),
        .we      (we),
        .f_rd    (arr_rbit[0]),
        .g_rd    (arr_rbit[1]),
        .f_we    (arr_we[0]),
        .f_waddr (arr_waddr[0]),
        .f_wbit  (arr_wbit[0]),
        .f_raddr (arr_raddr[0]),
        .g_we    (arr_we[1]),
        .g_waddr (arr_waddr[1]),
        .g_wbit  (arr_wbit[1]),
        .g_raddr (arr_raddr[1]),
        .dout_f  (dout_f),
        .dout_g  (dout_g)
    );

    // index 0 is the F array, index 1 the G array
    for (genvar gi = 0; gi < NARR; gi++) begin : g_arr
        lutram_array #(.AW(AW)) u_arr (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (arr_we[gi]),
            .wr_addr (arr_waddr[gi]),
            .wr_bit  (arr_wbit[gi]),
            .rd_addr (arr_raddr[gi]),
            .rd_bit  (arr_rbit[gi])
        );
    end

    // R9: mode holds while out of reset
    a_r9_mode_static: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(cfg_mode));

    // R7: both read ports agree when pointed at the same address
    a_r7_copies_agree: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LM_DUAL && addr_f == addr_g) |-> (dout_f == dout_g));

    // R4: a split-mode write is visible on dout_f after the edge
    a_r4_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd0 && we) ##1 $stable(addr_f) |-> (dout_f == $past(din0)));

    // R3: no enabled write and steady read inputs means steady outputs
    a_r3_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !we ##1 ($stable(addr_f) && $stable(addr_g) && $stable(din1) && $stable(cfg_mode))
        |-> ($stable(dout_f) && $stable(dout_g)));

endmodule

// File: tb/lutram_tile_bench.sv
module lutram_tile_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cfg_mode = 2'd0;
    logic [3:0] addr_f = 4'd0;
    logic [3:0] addr_g = 4'd0;
    logic       din0 = 1'b0;
    logic       din1 = 1'b0;
    logic       we = 1'b0;
    logic       dout_f;
    logic       dout_g;

    int n_run = 0;
    int n_fail = 0;

    logic rf [16];
    logic rg [16];

    always #5 clk = ~clk;

    lutram_tile u_lutram_tile (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_mode (cfg_mode),
        .addr_f   (addr_f),
        .addr_g   (addr_g),
        .din0     (din0),
        .din1     (din1),
        .we       (we),
        .dout_f   (dout_f),
        .dout_g   (dout_g)
    );

    task automatic check(input string tag, input logic act, input logic exp, input string what);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b (mode %0d af %0d ag %0d d1 %b)",
                     tag, what, act, exp, cfg_mode, addr_f, addr_g, din1);
        end
    endtask

    function automatic logic exp_f();
        if (cfg_mode == 2'd1) return din1 ? rg[addr_f] : rf[addr_f];
        return rf[addr_f];
    endfunction

    function automatic logic exp_g();
        if (cfg_mode == 2'd1) return din1 ? rg[addr_f] : rf[addr_f];
        return rg[addr_g];
    endfunction

    task automatic model_write();
        if (!we) return;
        case (cfg_mode)
            2'd1: if (din1) rg[addr_f] = din0; else rf[addr_f] = din0;
            2'd2: begin rf[addr_f] = din0; rg[addr_f] = din0; end
            default: begin rf[addr_f] = din0; rg[addr_g] = din1; end
        endcase
    endtask

    // one cycle: drive at the falling edge, check before and after the rising edge
    task automatic step(input logic [3:0] af, input logic [3:0] ag,
                        input logic d0, input logic d1, input logic w, input string tag);
        @(negedge clk);
        addr_f = af; addr_g = ag; din0 = d0; din1 = d1; we = w;
        #2;
        check(tag, dout_f, exp_f(), "dout_f pre-edge");
        check(tag, dout_g, exp_g(), "dout_g pre-edge");
        @(posedge clk);
        model_write();
        #1;
        check(tag, dout_f, exp_f(), "dout_f post-edge");
        check(tag, dout_g, exp_g(), "dout_g post-edge");
    endtask

    task automatic do_reset(input logic [1:0] m);
        @(negedge clk);
        rst_n = 1'b0; we = 1'b0; cfg_mode = m;
        for (int i = 0; i < 16; i++) begin rf[i] = 1'b0; rg[i] = 1'b0; end
        #2;
        check("R1", dout_f, 1'b0, "dout_f in reset");
        check("R1", dout_g, 1'b0, "dout_g in reset");
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // split 16x2: reset contents, fill, full address-pair sweep
        do_reset(2'd0);
        for (int i = 0; i < 16; i++) step(4'(i), 4'(15 - i), 1'b0, 1'b0, 1'b0, "R1");
        for (int i = 0; i < 16; i++)
            step(4'(i), 4'(15 - i), logic'(i % 3 == 0), logic'(i[0] ^ i[2]), 1'b1, "R4");
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++) step(4'(a), 4'(b), 1'b0, 1'b0, 1'b0, "R2");
        // equal addresses in split mode
        step(4'd5, 4'd5, 1'b1, 1'b0, 1'b1, "R4");
        step(4'd5, 4'd5, 1'b0, 1'b1, 1'b0, "R4");
        // enable low with toggling data: nothing stored
        for (int i = 0; i < 16; i++) step(4'(i), 4'(i), ~rf[i], ~rg[i], 1'b0, "R3");

        // wide 32x1: fill all 32 entries, read back with scrambled addr_g
        do_reset(2'd1);
        for (int e = 0; e < 32; e++) step(4'(e), 4'(e * 7), 1'b0, logic'(e / 16), 1'b0, "R1");
        for (int e = 0; e < 16; e++) step(4'(e), 4'd0, logic'((e * 5) % 3 == 1), 1'b0, 1'b1, "R6");
        for (int e = 0; e < 16; e++) step(4'(e), 4'(e * 3), 1'b0, 1'b1, 1'b0, "R6");
        for (int e = 16; e < 32; e++) step(4'(e), 4'(e), logic'(e[1] | e[3]), 1'b1, 1'b1, "R5");
        for (int e = 0; e < 32; e++) step(4'(e), 4'(e * 7 + 3), 1'b0, logic'(e / 16), 1'b0, "R5");
        for (int e = 0; e < 32; e++) step(4'(e), 4'(e), 1'b1, logic'(e / 16), 1'b0, "R3");

        // dual-port: fill via F side, sweep second read port
        do_reset(2'd2);
        for (int i = 0; i < 16; i++) step(4'(i), 4'(i), logic'(i[0] ^ i[1] ^ i[3]), ~i[0], 1'b1, "R7");
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++) step(4'(a), 4'(b), 1'b0, 1'b1, 1'b0, "R7");
        // same-address read/write: old before, new after
        for (int i = 0; i < 16; i++) step(4'(i), 4'(i), ~rf[i], 1'b0, 1'b1, "R8");
        for (int i = 0; i < 16; i++) step(4'(i), 4'((i + 1) % 16), ~rf[i], 1'b1, 1'b1, "R8");

        // reserved code acts as split mode
        do_reset(2'd3);
        for (int i = 0; i < 16; i++) step(4'(i), 4'(i ^ 4'hA), logic'(i[2]), logic'(~i[1]), 1'b1, "R9");
        for (int i = 0; i < 16; i++) step(4'(i), 4'(i), 1'b0, 1'b0, 1'b0, "R9");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule